// File: doc/BRIEF.md
# UART Bus Register Front-End

This block is the bus side of a small serial peripheral. A 32-bit word-addressed read/write port reaches four registers. It accepts incoming bytes from a receive byte stream into an eight-entry FIFO. It passes transmit bytes out on a second byte stream. It also assembles a status word and raises one interrupt line. The bit-level serializer, the deserializer and the baud logic live elsewhere. The three line-error flags arrive as plain inputs and are only reported.

Software drains received bytes by reading the receive-data register, and each such read removes the byte it returns. A status read acknowledges the interrupt. Writing the control register can flush either direction and set the interrupt enable. The bus presents at most one access per cycle, and a write wins if both strobes are high. Read data is combinational: it is valid in the same cycle as `busRdEn`, and any side effect of the read takes place at the closing clock edge.

Top module: `uart_reg_top`

## Requirements
- R1: After reset the status word reads 0x04, `irq` is low, `rxReady` is high and `txValid` is low.
- R2: `busAddr[3:2]` selects receive data (0), transmit data (1), status (2) or control (3), and `busAddr[1:0]` is ignored. Any access with a nonzero address bit above bit 3 reads zero and changes nothing.
- R3: A byte is taken in every cycle in which `rxValid` and `rxReady` are both high. Receive-data reads return bytes in arrival order, zero-extended, and each read removes the byte it returns. A push and a pop in the same cycle leave the fill level unchanged.
- R4: With eight bytes held, `rxReady` is low, status bit 1 is set, and an offered byte is dropped.
- R5: A receive-data read while the FIFO is empty returns zero and leaves the FIFO empty.
- R6: Status bit 0 means the FIFO holds a byte. Bit 1 means it holds eight. Bit 2 means no transmit byte is waiting, and bit 3 means one is. Bits 5, 6 and 7 follow `errOverrun`, `errFrame` and `errParity`.
- R7: A control write with bit 1 set empties the receive FIFO. Every control write stores the full word, and a control read returns it.
- R8: A transmit-data write drives its low byte on `txData` with `txValid` high until `txReady` accepts it. A write made while an earlier byte waits and is not accepted in that cycle is dropped. The register reads back the last word written.
- R9: A control write with bit 0 set discards a waiting transmit byte.
- R10: Every transmit-data write sets the interrupt-pending flag (status bit 4).
- R11: The pending flag is set whenever the receive FIFO holds a byte. A status read returns the flag as it was, then clears it unless the FIFO still holds a byte after that cycle.
- R12: `irq` is high exactly when the pending flag and control bit 4 are both set.
- R13: Writes to the status register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Byte address of the access |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busWData | input | DATA_W | Write data |
| busRData | output | DATA_W | Read data, same cycle as busRdEn |
| rxData | input | BYTE_W | Incoming byte |
| rxValid | input | 1 | Incoming byte offered |
| rxReady | output | 1 | FIFO can take a byte |
| txData | output | BYTE_W | Outgoing byte |
| txValid | output | 1 | Outgoing byte waiting |
| txReady | input | 1 | Downstream takes the byte |
| errOverrun | input | 1 | Overrun flag from the line side |
| errFrame | input | 1 | Framing flag from the line side |
| errParity | input | 1 | Parity flag from the line side |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a receive-data read that lands in the same cycle as an incoming byte. The pop and the push then have to cancel in the fill count while the pointers still move apart. The bench sets `rxValid` and the read strobe in the same cycle on a one-entry FIFO. It then checks that the old byte is returned, the new one follows, and the FIFO is empty afterwards. A second case drives the FIFO past full with the stream held valid. This shows that the ninth byte is never stored and that wrap-around of the pointers keeps the order intact.

// File: rtl/uart_reg_pkg.sv
package uart_reg_pkg;

  typedef enum logic [1:0] {
    REG_RXDATA = 2'd0,
    REG_TXDATA = 2'd1,
    REG_STATUS = 2'd2,
    REG_CTRL   = 2'd3
  } regSelT;

  localparam int ST_RX_VALID = 0;
  localparam int ST_RX_FULL  = 1;
  localparam int ST_TX_EMPTY = 2;
  localparam int ST_TX_FULL  = 3;
  localparam int ST_PENDING  = 4;
  localparam int ST_OVERRUN  = 5;
  localparam int ST_FRAME    = 6;
  localparam int ST_PARITY   = 7;

  localparam int CTL_TX_RST = 0;
  localparam int CTL_RX_RST = 1;
  localparam int CTL_IRQ_EN = 4;

  typedef struct packed {
    logic rxPop;
    logic rxFlush;
    logic txLoad;
    logic txFlush;
    logic ctrlWr;
    logic pendClr;
  } strobeT;

endpackage

// File: rtl/uart_reg_ctrl.sv
module uart_reg_ctrl
  import uart_reg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6,
  parameter int BYTE_W = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [DATA_W-1:0] busWData,
  input  logic [DATA_W-1:0] statusWord,
  input  logic [DATA_W-1:0] ctrlWord,
  input  logic [DATA_W-1:0] txWord,
  input  logic [BYTE_W-1:0] rxHead,
  output strobeT            strobes,
  output logic [DATA_W-1:0] busRData
);

  localparam int SEL_LSB = 2;
  localparam int SEL_W   = 2;
  localparam int TOP_LSB = SEL_LSB + SEL_W;

  logic   inRange;
  logic   wrHit;
  logic   rdHit;
  regSelT sel;
  logic   unusedAddr;

  assign unusedAddr = ^busAddr[SEL_LSB-1:0];
  assign inRange = (busAddr[ADDR_W-1:TOP_LSB] == '0);
  assign sel     = regSelT'(busAddr[SEL_LSB +: SEL_W]);
  assign wrHit   = busWrEn & inRange;
  assign rdHit   = busRdEn & ~busWrEn & inRange;

  always_comb begin
    strobes         = '0;
    strobes.rxPop   = rdHit && (sel == REG_RXDATA);
    strobes.pendClr = rdHit && (sel == REG_STATUS);
    strobes.txLoad  = wrHit && (sel == REG_TXDATA);
    strobes.ctrlWr  = wrHit && (sel == REG_CTRL);
    strobes.rxFlush = strobes.ctrlWr & busWData[CTL_RX_RST];
    strobes.txFlush = strobes.ctrlWr & busWData[CTL_TX_RST];
  end

  always_comb begin
    busRData = '0;
    if (rdHit) begin
      unique case (sel)
        REG_RXDATA: if (statusWord[ST_RX_VALID]) busRData = DATA_W'(rxHead);
        REG_TXDATA: busRData = txWord;
        REG_STATUS: busRData = statusWord;
        REG_CTRL:   busRData = ctrlWord;
        default:    busRData = '0;
      endcase
    end
  end

endmodule

// File: rtl/uart_reg_data.sv
module uart_reg_data
  import uart_reg_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int BYTE_W     = 8,
  parameter int FIFO_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobes,
  input  logic [DATA_W-1:0] busWData,
  input  logic [BYTE_W-1:0] rxData,
  input  logic              rxValid,
  output logic              rxReady,
  output logic [BYTE_W-1:0] txData,
  output logic              txValid,
  input  logic              txReady,
  input  logic              errOverrun,
  input  logic              errFrame,
  input  logic              errParity,
  output logic [DATA_W-1:0] statusWord,
  output logic [DATA_W-1:0] ctrlWord,
  output logic [DATA_W-1:0] txWord,
  output logic [BYTE_W-1:0] rxHead,
  output logic              irq
);

  localparam int PTR_W = $clog2(FIFO_DEPTH);
  localparam int CNT_W = PTR_W + 1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FIFO_DEPTH);

  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] rxCount, countNext;
  logic             rxFull, rxEmpty, rxPush, rxPopOk;
  logic [FIFO_DEPTH-1:0][BYTE_W-1:0] slotFlat;

  logic             txFull;
  logic [BYTE_W-1:0] txByte;
  logic             txAccept;
  logic             pend;

  // receive FIFO fill state
  assign rxFull  = (rxCount == CNT_FULL);
  assign rxEmpty = (rxCount == '0);
  assign rxReady = ~rxFull;
  assign rxPush  = rxValid & ~rxFull & ~strobes.rxFlush;
  assign rxPopOk = strobes.rxPop & ~rxEmpty;

  always_comb begin
    countNext = rxCount;
    if (strobes.rxFlush)       countNext = '0;
    else if (rxPush & ~rxPopOk) countNext = rxCount + CNT_W'(1);
    else if (~rxPush & rxPopOk) countNext = rxCount - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      rxCount <= '0;
    end else begin
      rxCount <= countNext;
      if (strobes.rxFlush) begin
        wrPtr <= '0;
        rdPtr <= '0;
      end else begin
        if (rxPush)  wrPtr <= wrPtr + PTR_W'(1);
        if (rxPopOk) rdPtr <= rdPtr + PTR_W'(1);
      end
    end
  end

  // one storage slot per FIFO entry
  for (genvar i = 0; i < FIFO_DEPTH; i++) begin : g_slot
    logic [BYTE_W-1:0] slotQ;
    always_ff @(posedge clk) begin
      if (!rstN)                                  slotQ <= '0;
      else if (rxPush && (wrPtr == PTR_W'(i)))    slotQ <= rxData;
    end
    assign slotFlat[i] = slotQ;
  end

  assign rxHead = slotFlat[rdPtr];

  // single-byte transmit holding stage
  assign txAccept = txFull & txReady;
  assign txValid  = txFull;
  assign txData   = txByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txFull <= 1'b0;
      txByte <= '0;
    end else if (strobes.txFlush) begin
      txFull <= 1'b0;
    end else if (strobes.txLoad && (!txFull || txReady)) begin
      txFull <= 1'b1;
      txByte <= busWData[BYTE_W-1:0];
    end else if (txAccept) begin
      txFull <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txWord   <= '0;
      ctrlWord <= '0;
    end else begin
      if (strobes.txLoad) txWord   <= busWData;
      if (strobes.ctrlWr) ctrlWord <= busWData;
    end
  end

  // sticky interrupt-pending flag
  always_ff @(posedge clk) begin
    if (!rstN) pend <= 1'b0;
    else       pend <= (pend & ~strobes.pendClr) | strobes.txLoad | (countNext != '0);
  end

  always_comb begin
    statusWord              = '0;
    statusWord[ST_RX_VALID] = ~rxEmpty;
    statusWord[ST_RX_FULL]  = rxFull;
    statusWord[ST_TX_EMPTY] = ~txFull;
    statusWord[ST_TX_FULL]  = txFull;
    statusWord[ST_PENDING]  = pend;
    statusWord[ST_OVERRUN]  = errOverrun;
    statusWord[ST_FRAME]    = errFrame;
    statusWord[ST_PARITY]   = errParity;
  end

  assign irq = pend & ctrlWord[CTL_IRQ_EN];

endmodule

// File: rtl/uart_reg_top.sv
module uart_reg_top
  import uart_reg_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 6,
  parameter int BYTE_W     = 8,
  parameter int FIFO_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [DATA_W-1:0] busWData,
  output logic [DATA_W-1:0] busRData,
  input  logic [BYTE_W-1:0] rxData,
  input  logic              rxValid,
  output logic              rxReady,
  output logic [BYTE_W-1:0] txData,
  output logic              txValid,
  input  logic              txReady,
  input  logic              errOverrun,
  input  logic              errFrame,
  input  logic              errParity,
  output logic              irq
);

  strobeT            strobes;
  logic [DATA_W-1:0] statusWord;
  logic [DATA_W-1:0] ctrlWord;
  logic [DATA_W-1:0] txWord;
  logic [BYTE_W-1:0] rxHead;

  uart_reg_ctrl #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BYTE_W(BYTE_W)
  ) u_ctrl (
    .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn), .busWData(busWData),
    .statusWord(statusWord), .ctrlWord(ctrlWord), .txWord(txWord), .rxHead(rxHead),
    .strobes(strobes), .busRData(busRData)
  );

  uart_reg_data #(
    .DATA_W(DATA_W), .BYTE_W(BYTE_W), .FIFO_DEPTH(FIFO_DEPTH)
  ) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busWData(busWData),
    .rxData(rxData), .rxValid(rxValid), .rxReady(rxReady),
    .txData(txData), .txValid(txValid), .txReady(txReady),
    .errOverrun(errOverrun), .errFrame(errFrame), .errParity(errParity),
    .statusWord(statusWord), .ctrlWord(ctrlWord), .txWord(txWord),
    .rxHead(rxHead), .irq(irq)
  );

endmodule

// File: rtl/uart_reg_chk.sv
module uart_reg_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic              busRdEn,
  input logic [DATA_W-1:0] busWData,
  input logic [DATA_W-1:0] busRData,
  input logic              rxValid,
  input logic              rxReady,
  input logic [BYTE_W-1:0] txData,
  input logic              txValid,
  input logic              txReady,
  input logic [DATA_W-1:0] statusWord,
  input logic              irq
);

  localparam logic [ADDR_W-1:0] A_TX   = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(12);

  AST_OUT_OF_RANGE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && !busWrEn && (busAddr[ADDR_W-1:4] != '0)) |-> (busRData == '0)); // R2

  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[1] |-> !rxReady); // R4

  AST_FILL_BY_PUSH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rxReady) |-> $past(rxValid)); // R4

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady && !busWrEn) |=> (txValid && $stable(txData))); // R8

  AST_TX_WRITE_PEND: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == A_TX) |=> statusWord[4]); // R10

  AST_PEND_WITH_DATA: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[0] |-> statusWord[4]); // R11

  AST_STATUS_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && !busWrEn && busAddr == A_STAT && !statusWord[0] && !rxValid) |=> !statusWord[4]); // R11

  AST_IRQ_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == A_CTRL && !busWData[4]) |=> !irq); // R12

endmodule

bind uart_reg_top uart_reg_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BYTE_W(BYTE_W)
) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn),
  .busWData(busWData), .busRData(busRData), .rxValid(rxValid), .rxReady(rxReady),
  .txData(txData), .txValid(txValid), .txReady(txReady), .statusWord(statusWord),
  .irq(irq)
);

// File: tb/uart_reg_top_tb.sv
`timescale 1ns/1ps
module uart_reg_top_tb;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 6;
  localparam int BYTE_W = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic              busWrEn = 1'b0;
  logic              busRdEn = 1'b0;
  logic [DATA_W-1:0] busWData = '0;
  logic [DATA_W-1:0] busRData;
  logic [BYTE_W-1:0] rxData = '0;
  logic              rxValid = 1'b0;
  logic              rxReady;
  logic [BYTE_W-1:0] txData;
  logic              txValid;
  logic              txReady = 1'b0;
  logic              errOverrun = 1'b0;
  logic              errFrame = 1'b0;
  logic              errParity = 1'b0;
  logic              irq;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  uart_reg_top u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busWData(busWData), .busRData(busRData), .rxData(rxData), .rxValid(rxValid),
    .rxReady(rxReady), .txData(txData), .txValid(txValid), .txReady(txReady),
    .errOverrun(errOverrun), .errFrame(errFrame), .errParity(errParity), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    busAddr = a; busWData = d; busWrEn = 1'b1;
    @(posedge clk); #1;
    busWrEn = 1'b0;
  endtask

  task automatic busRd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    busAddr = a; busRdEn = 1'b1;
    #1 d = busRData;
    @(posedge clk); #1;
    busRdEn = 1'b0;
  endtask

  task automatic pushByte(input logic [7:0] b);
    rxData = b; rxValid = 1'b1;
    @(posedge clk); #1;
    rxValid = 1'b0;
  endtask

  task automatic testReset();
    logic [31:0] d;
    check("R1 rxReady", 32'(rxReady), 32'd1);
    check("R1 txValid", 32'(txValid), 32'd0);
    check("R1 irq", 32'(irq), 32'd0);
    busRd(6'h08, d);
    check("R1 status", d, 32'h04);
  endtask

  task automatic testRxOrder();
    logic [31:0] d;
    pushByte(8'hA1); pushByte(8'hB2); pushByte(8'hC3);
    busRd(6'h08, d); check("R6 R11 status with data", d, 32'h15);
    busRd(6'h00, d); check("R3 first byte", d, 32'hA1);
    busRd(6'h01, d); check("R2 R3 low bits ignored", d, 32'hB2);
    busRd(6'h00, d); check("R3 third byte", d, 32'hC3);
    busRd(6'h08, d); check("R11 status before clear", d, 32'h14);
    busRd(6'h08, d); check("R11 status after clear", d, 32'h04);
  endtask

  task automatic testFull();
    logic [31:0] d;
    for (int i = 0; i < 8; i++) pushByte(8'(8'h40 + i));
    check("R4 rxReady low", 32'(rxReady), 32'd0);
    busRd(6'h08, d); check("R4 R6 status full", d, 32'h17);
    pushByte(8'h48);
    for (int i = 0; i < 8; i++) begin
      busRd(6'h00, d); check("R4 drain order", d, 32'(8'h40 + i));
    end
    busRd(6'h00, d); check("R4 R5 ninth byte dropped", d, 32'h0);
    busRd(6'h08, d); check("R5 status after drain", d, 32'h14);
  endtask

  task automatic testEmptyRead();
    logic [31:0] d;
    busRd(6'h00, d); check("R5 empty read", d, 32'h0);
    pushByte(8'h3C);
    busRd(6'h00, d); check("R5 byte after empty read", d, 32'h3C);
    busRd(6'h08, d); check("R5 empty again", d, 32'h14);
  endtask

  task automatic testPushPop();
    logic [31:0] d;
    pushByte(8'h11);
    rxData = 8'h22; rxValid = 1'b1;
    busAddr = 6'h00; busRdEn = 1'b1;
    #1 d = busRData;
    @(posedge clk); #1;
    busRdEn = 1'b0; rxValid = 1'b0;
    check("R3 pop during push", d, 32'h11);
    busRd(6'h08, d); check("R3 level kept", d, 32'h15);
    busRd(6'h00, d); check("R3 pushed byte", d, 32'h22);
    busRd(6'h08, d); check("R3 empty after", d, 32'h14);
    busRd(6'h08, d);
  endtask

  task automatic testFlush();
    logic [31:0] d;
    pushByte(8'h01); pushByte(8'h02); pushByte(8'h03);
    busWr(6'h0C, 32'h0000_0002);
    busRd(6'h0C, d); check("R7 ctrl readback", d, 32'h02);
    busRd(6'h08, d); check("R7 status after flush", d, 32'h14);
    busRd(6'h00, d); check("R7 flushed read", d, 32'h0);
    pushByte(8'h5A);
    busRd(6'h00, d); check("R7 byte after flush", d, 32'h5A);
    busRd(6'h08, d);
  endtask

  task automatic testTx();
    logic [31:0] d;
    txReady = 1'b0;
    busWr(6'h04, 32'h1234_56AB);
    check("R8 txValid", 32'(txValid), 32'd1);
    check("R8 txData", 32'(txData), 32'hAB);
    busRd(6'h08, d); check("R6 R10 status tx full", d, 32'h18);
    busWr(6'h04, 32'h0000_99CD);
    check("R8 second write dropped", 32'(txData), 32'hAB);
    busRd(6'h04, d); check("R8 tx readback", d, 32'h0000_99CD);
    txReady = 1'b1;
    @(posedge clk); #1;
    txReady = 1'b0;
    check("R8 accepted", 32'(txValid), 32'd0);
    busRd(6'h08, d); check("R10 pending after tx", d, 32'h14);
  endtask

  task automatic testTxFlush();
    logic [31:0] d;
    busWr(6'h04, 32'h77);
    check("R9 waiting", 32'(txValid), 32'd1);
    busWr(6'h0C, 32'h01);
    check("R9 discarded", 32'(txValid), 32'd0);
    busRd(6'h08, d); check("R9 status", d, 32'h14);
  endtask

  task automatic testIrq();
    logic [31:0] d;
    busWr(6'h0C, 32'h10);
    check("R12 enabled no pending", 32'(irq), 32'd0);
    busWr(6'h04, 32'h55);
    check("R12 irq on tx write", 32'(irq), 32'd1);
    txReady = 1'b1; @(posedge clk); #1; txReady = 1'b0;
    busRd(6'h08, d);
    check("R12 irq cleared by status read", 32'(irq), 32'd0);
    busWr(6'h0C, 32'h00);
    pushByte(8'h99);
    check("R12 masked", 32'(irq), 32'd0);
    busRd(6'h08, d); check("R12 pending while masked", d, 32'h15);
    busRd(6'h00, d);
    busRd(6'h08, d);
  endtask

  task automatic testStatusWrite();
    logic [31:0] d;
    busWr(6'h08, 32'hFFFF_FFFF);
    busRd(6'h08, d); check("R13 status unchanged", d, 32'h04);
  endtask

  task automatic testOutOfRange();
    logic [31:0] d;
    busWr(6'h0C, 32'h01);
    pushByte(8'h66);
    busWr(6'h1C, 32'h13);
    busRd(6'h1C, d); check("R2 out of range reads zero", d, 32'h0);
    busRd(6'h0C, d); check("R2 ctrl untouched", d, 32'h01);
    busRd(6'h20, d); check("R2 aliased rx read zero", d, 32'h0);
    busRd(6'h00, d); check("R2 byte not popped", d, 32'h66);
    busRd(6'h08, d);
  endtask

  task automatic testErrFlags();
    logic [31:0] d;
    errOverrun = 1'b1; errFrame = 1'b1; errParity = 1'b0;
    busRd(6'h08, d); check("R6 error bits", d, 32'h64);
    errOverrun = 1'b0; errFrame = 1'b0; errParity = 1'b1;
    busRd(6'h08, d); check("R6 parity bit", d, 32'h84);
    errParity = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    testRxOrder();
    testFull();
    testEmptyRead();
    testPushPop();
    testFlush();
    testTx();
    testTxFlush();
    testIrq();
    testStatusWrite();
    testOutOfRange();
    testErrFlags();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule